// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Timer

This block generates a single output pulse whose length is a programmable number of clock cycles. It is a synchronous, counter-based stand-in for a retriggerable monostable pulse generator. Three edge sources can start the pulse:

- a falling edge on the active-low trigger `trig_n`;
- a rising edge on the active-high trigger `trig_p`;
- a rising edge on the active-low clear `clear_n`.

Each source is qualified by the levels of the other two inputs. A new valid trigger during a pulse restarts the full interval. A low level on the clear input cuts the pulse short and holds the block idle. After any clear, a recovery window must pass before a trigger is honoured.

All inputs are already synchronous to `clk`. Edges are found by comparing each input with its value from the previous cycle. The length setting on `width` is captured only when a trigger is accepted.

Top module: `retrig_oneshot`

## Requirements
- R1: After the synchronous reset `rst`, and while no trigger occurs, `pulse` is 0 and `pulse_n` is 1.
- R2: A `trig_n` falling edge, seen while `trig_p`=1 and `clear_n`=1, raises `pulse` at that clock edge. `pulse` then stays high for exactly `width` cycles, with `width`=0 treated as 1.
- R3: A `trig_p` rising edge, seen while `trig_n`=0 and `clear_n`=1, starts a pulse of the same length.
- R4: A `clear_n` rising edge, seen while `trig_n`=0 and `trig_p`=1, starts a pulse of the same length. This holds only if the recovery window has expired.
- R5: Unqualified activity never starts a pulse. This covers:
  - a `trig_n` fall while `trig_p`=0;
  - a `trig_p` rise while `trig_n`=1;
  - a `clear_n` rise while `trig_n`=1;
  - rising `trig_n`, falling `trig_p`, and static levels.
- R6: A valid trigger while `pulse` is high reloads the interval. `pulse` falls exactly `width` cycles after the last accepted trigger.
- R7: `clear_n` sampled low drives `pulse` low at that edge and cuts any active pulse short. While `clear_n` stays low, all triggers are ignored.
- R8: Counting from the edge that samples `clear_n` falling, triggers seen on the next RECOVER_CYCLES edges are dropped. The first edge that can accept a trigger is RECOVER_CYCLES+1 edges later. So a clear-rising trigger is accepted only if `clear_n` was held low for more than RECOVER_CYCLES cycles.
- R9: `pulse_n` is always the complement of `pulse`.
- R10: Changing `width` during a pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_n | input | 1 | Active-low trigger, fires on its falling edge |
| trig_p | input | 1 | Active-high trigger, fires on its rising edge |
| clear_n | input | 1 | Active-low clear; its rising edge is also a trigger |
| width | input | WIDTH_W | Pulse length in cycles, captured on trigger |
| pulse | output | 1 | Pulse output |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
The bound checker watches the following on every cycle:
- each qualified edge outside recovery raises the output on the next edge;
- a low clear forces the output low;
- the output stays low throughout the recovery window;
- a running pulse with more than one cycle left cannot drop without a clear.

Exact pulse lengths need the bench's scenarios. So do retrigger extension by a measured offset, the point where recovery ends for each trigger source, and the fact that a changed length setting does not reach a running pulse. The bench shows these by sweeping the length setting, the retrigger offset, the clear-low duration and the trigger time after a clear.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Sampled levels of the three control inputs.
    typedef struct packed {
        logic trig_n;
        logic trig_p;
        logic clear_n;
    } os_pins_t;

    // Edge events derived from one cycle of history.
    typedef struct packed {
        logic trig_fall;
        logic trig_rise;
        logic clear_rise;
        logic clear_fall;
    } os_edges_t;

    // Idle levels used as history after reset.
    localparam os_pins_t OS_IDLE = '{trig_n: 1'b1, trig_p: 1'b0, clear_n: 1'b1};

    // Counter width able to hold the value n (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/os_edge_detect.sv
module os_edge_detect
    import oneshot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  os_pins_t  pins,
    output os_edges_t edges
);
    os_pins_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= OS_IDLE;
        else     prev <= pins;
    end

    always_comb begin
        edges.trig_fall  =  prev.trig_n  & ~pins.trig_n;
        edges.trig_rise  = ~prev.trig_p  &  pins.trig_p;
        edges.clear_rise = ~prev.clear_n &  pins.clear_n;
        edges.clear_fall =  prev.clear_n & ~pins.clear_n;
    end
endmodule

// File: rtl/os_trig_qualify.sv
module os_trig_qualify
    import oneshot_pkg::*;
(
    input  os_pins_t  pins,
    input  os_edges_t edges,
    input  logic      busy,
    output logic      accept
);
    logic via_fall, via_rise, via_clear;

    always_comb begin
        via_fall  = edges.trig_fall  &  pins.trig_p & pins.clear_n;
        via_rise  = edges.trig_rise  & ~pins.trig_n & pins.clear_n;
        via_clear = edges.clear_rise & ~pins.trig_n & pins.trig_p;
        accept    = (via_fall | via_rise | via_clear) & ~busy;
    end
endmodule

// File: rtl/os_recovery.sv
module os_recovery
    import oneshot_pkg::*;
#(
    parameter int unsigned RECOVER_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_fall,
    output logic busy
);
    localparam int unsigned REC_W = cnt_width(RECOVER_CYCLES);
    localparam logic [REC_W-1:0] REC_LOAD = REC_W'(RECOVER_CYCLES);

    logic [REC_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (clear_fall)
            remain <= REC_LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer #(
    parameter int unsigned WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear_n,
    input  logic               accept,
    input  logic [WIDTH_W-1:0] width,
    output logic               active,
    output logic [WIDTH_W-1:0] remain
);
    logic [WIDTH_W-1:0] load_val;

    // A zero setting still yields one cycle of output.
    assign load_val = (width == '0) ? WIDTH_W'(1) : width;

    always_ff @(posedge clk) begin
        if (rst || !clear_n)
            remain <= '0;
        else if (accept)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign active = (remain != '0);
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int unsigned WIDTH_W        = 8,
    parameter int unsigned RECOVER_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_n,
    input  logic               trig_p,
    input  logic               clear_n,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse,
    output logic               pulse_n
);
    os_pins_t           pins;
    os_edges_t          edges;
    logic               rec_busy;
    logic               trig_accept;
    logic               tmr_active;
    logic [WIDTH_W-1:0] tmr_remain;

    assign pins = '{trig_n: trig_n, trig_p: trig_p, clear_n: clear_n};

    os_edge_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .pins  (pins),
        .edges (edges)
    );

    os_recovery #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_rec (
        .clk        (clk),
        .rst        (rst),
        .clear_fall (edges.clear_fall),
        .busy       (rec_busy)
    );

    os_trig_qualify u_qual (
        .pins   (pins),
        .edges  (edges),
        .busy   (rec_busy),
        .accept (trig_accept)
    );

    os_pulse_timer #(.WIDTH_W(WIDTH_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear_n (clear_n),
        .accept  (trig_accept),
        .width   (width),
        .active  (tmr_active),
        .remain  (tmr_remain)
    );

    assign pulse   = tmr_active;
    assign pulse_n = ~tmr_active;
endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
    parameter int unsigned WIDTH_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               trig_n,
    input logic               trig_p,
    input logic               clear_n,
    input logic               pulse,
    input logic               busy,
    input logic               accept,
    input logic [WIDTH_W-1:0] remain
);
    logic h_trig_n, h_trig_p, h_clear_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_trig_n  <= 1'b1;
            h_trig_p  <= 1'b0;
            h_clear_n <= 1'b1;
        end else begin
            h_trig_n  <= trig_n;
            h_trig_p  <= trig_p;
            h_clear_n <= clear_n;
        end
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !pulse);

    a_r2_fall_starts: assert property (@(posedge clk) disable iff (rst)
        (h_trig_n && !trig_n && trig_p && clear_n && !busy) |=> pulse);

    a_r3_rise_starts: assert property (@(posedge clk) disable iff (rst)
        (!h_trig_p && trig_p && !trig_n && clear_n && !busy) |=> pulse);

    a_r4_clear_starts: assert property (@(posedge clk) disable iff (rst)
        (!h_clear_n && clear_n && !trig_n && trig_p && !busy) |=> pulse);

    a_r6_holds_high: assert property (@(posedge clk) disable iff (rst)
        (pulse && !accept && clear_n && remain > WIDTH_W'(1)) |=> pulse);

    a_r7_clear_forces_low: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> !pulse);

    a_r8_recovery_blocks: assert property (@(posedge clk) disable iff (rst)
        busy |=> !pulse);
endmodule

bind retrig_oneshot retrig_oneshot_chk #(.WIDTH_W(WIDTH_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .trig_n  (trig_n),
    .trig_p  (trig_p),
    .clear_n (clear_n),
    .pulse   (pulse),
    .busy    (rec_busy),
    .accept  (trig_accept),
    .remain  (tmr_remain)
);

// File: tb/tb_retrig_oneshot.sv
`timescale 1ns/1ps
module tb_retrig_oneshot;
    localparam int PW  = 4;
    localparam int REC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_n = 1'b1;
    logic          trig_p = 1'b0;
    logic          clear_n = 1'b1;
    logic [PW-1:0] width = PW'(5);
    logic          pulse, pulse_n;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2.5 clk = ~clk;

    retrig_oneshot #(.WIDTH_W(PW), .RECOVER_CYCLES(REC)) dut (
        .clk(clk), .rst(rst), .trig_n(trig_n), .trig_p(trig_p),
        .clear_n(clear_n), .width(width), .pulse(pulse), .pulse_n(pulse_n)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_q(input string req, input int exp);
        check(req, int'(pulse), exp);
        check("R9 complement", int'(pulse_n), int'(!pulse));
    endtask

    task automatic measure(output int w);
        w = 0;
        while (pulse === 1'b1 && w < 60) begin
            w++;
            tick();
        end
    endtask

    initial begin
        int w;
        repeat (3) tick();
        check_q("R1 in reset", 0);
        rst = 1'b0;
        repeat (5) tick();
        check_q("R1 idle", 0);

        // R5: trig_p rises while trig_n high
        trig_p = 1'b1; tick();
        check_q("R5 rise with trig_n high", 0);

        // R2: width sweep through the falling-edge source
        for (int p = 0; p < 16; p++) begin
            width = PW'(p);
            trig_n = 1'b0; tick();
            measure(w);
            check("R2 width", w, (p == 0) ? 1 : p);
            trig_n = 1'b1; tick();
            check_q("R5 trig_n rise", 0);
        end

        // R5: falling edge while trig_p low
        trig_p = 1'b0; tick();
        trig_n = 1'b0; tick();
        check_q("R5 fall with trig_p low", 0);
        repeat (3) tick();
        check_q("R5 static low level", 0);

        // R3: rising-edge source
        for (int i = 0; i < 4; i++) begin
            int p;
            p = (2 << i) - 1;
            width = PW'(p);
            trig_p = 1'b1; tick();
            measure(w);
            check("R3 width", w, p);
            trig_p = 1'b0; tick();
            check_q("R5 trig_p fall", 0);
        end
        trig_n = 1'b1; tick();

        // R4 / R8: clear-rising source vs. clear-low duration
        width = PW'(6);
        for (int len = 1; len <= 5; len++) begin
            clear_n = 1'b0; trig_n = 1'b0; trig_p = 1'b1; tick();
            check_q("R7 triggers ignored under clear", 0);
            repeat (len - 1) tick();
            clear_n = 1'b1; tick();
            measure(w);
            check((len > REC) ? "R4 clear-rise accepted" : "R8 clear-rise in recovery",
                  w, (len > REC) ? 6 : 0);
            trig_n = 1'b1; trig_p = 1'b0; tick();
        end

        // R5: clear rise with trig_n high
        trig_p = 1'b1; clear_n = 1'b0; repeat (5) tick();
        clear_n = 1'b1; tick();
        measure(w);
        check("R5 clear rise with trig_n high", w, 0);

        // R6: retrigger at offset k
        width = PW'(6);
        for (int k = 2; k <= 6; k++) begin
            trig_n = 1'b0; tick();
            trig_n = 1'b1;
            repeat (k - 1) tick();
            trig_n = 1'b0; tick();
            measure(w);
            check("R6 extended width", w + k, k + 6);
            trig_n = 1'b1; tick();
        end

        // R10: width changed during pulse
        width = PW'(4);
        trig_n = 1'b0; tick();
        width = PW'(15);
        measure(w);
        check("R10 width latched", w, 4);
        trig_n = 1'b1; tick();

        // R7: clear cuts a pulse and blocks triggers
        width = PW'(10);
        trig_n = 1'b0; tick(); tick(); tick();
        check_q("R2 pulse running", 1);
        clear_n = 1'b0; tick();
        check_q("R7 pulse cut", 0);
        trig_n = 1'b1; tick();
        trig_n = 1'b0; tick();
        check_q("R7 fall ignored", 0);
        trig_p = 1'b0; tick();
        trig_p = 1'b1; tick();
        check_q("R7 rise ignored", 0);
        trig_n = 1'b1; repeat (6) tick();
        clear_n = 1'b1; tick();
        check_q("R7 release idle", 0);

        // R8: falling-edge trigger e edges after the clear fall
        width = PW'(3);
        for (int e = 1; e <= 5; e++) begin
            clear_n = 1'b0; tick();
            clear_n = 1'b1;
            repeat (e - 1) tick();
            trig_n = 1'b0; tick();
            measure(w);
            check("R8 recovery window", w, (e >= REC + 1) ? 3 : 0);
            trig_n = 1'b1; tick();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule